// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does so by reading descriptors from a two-level translation table held in memory. A request gives the address, the kind of access (read, write or instruction fetch) and whether the access is from user level. The control inputs supply the table base, the per-domain access field word, a relocation offset for low addresses and three system control bits. The walker issues at most two descriptor reads over a simple read-request / read-response port.

The walker ends each request with a one-cycle `done` pulse. Along with the pulse it gives either a physical address with the granted read and write rights, or a fault status and the faulting address. A fault is also stored in one of two register pairs. Instruction fetches use the instruction-side pair and all other accesses use the data-side pair. The block holds no cached translations; any caching is left to the logic around it.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `mem_rd_valid`, `fault` and all four fault registers (`ifsr`, `ifar`, `dfsr`, `dfar`) are zero.
- R2: A request address below 0x02000000 has `proc_off` added to it before any other step. An address at or above that limit is used unchanged. The result is the working address, and it is also the one reported in `fault_addr`.
- R3: With `ctl_mmu_en` low, no memory read is issued. `pa` equals the working address, and both `perm_rd` and `perm_wr` are 1.
- R4: The first descriptor is read from {tbl_base[31:14], wa[31:20], 2'b00}, where wa is the working address. A first-level descriptor of type 2 (bits [1:0]) is a section. Its physical address is {desc[31:20], wa[19:0]} and its access field is desc[11:10].
- R5: The domain number is desc[8:5] of the first-level descriptor. It selects the access value dom_ctl[2n+1:2n]. Values 0 and 2 fault with code 9 for a section, or code 11 for a table (types 1 and 3); in the table case no second read is issued. Every fault status is {domain number, code} in 8 bits.
- R6: The second descriptor is read from {desc1[31:10], wa[19:12], 2'b00}. Type 1 maps 64 KB as {desc[31:16], wa[15:0]} and type 2 maps 4 KB as {desc[31:12], wa[11:0]}. For both, the access field is desc[5+2k:4+2k] with k = wa[15:14]. Type 3 maps 1 KB as {desc[31:10], wa[9:0]}, with its access field in desc[5:4].
- R7: A first-level type 0 faults with code 5 and a second-level type 0 faults with code 7.
- R8: Domain access value 3 grants read and write whatever the access field holds.
- R9: For domain access value 1, access field 3 grants read and write. Field 1 grants read and write to privileged accesses only. Field 2 grants read and write to privileged accesses and read only to user accesses. When nothing is granted to the access, it faults with code 13 for a section or 15 for a page, and both rights are reported as 0.
- R10: Access field 0 grants nothing to writes. A read or fetch is judged on {ctl_rom, ctl_sys}: 01 grants read to privileged accesses only, 10 grants read to all, and 00 or 11 grants nothing.
- R11: A fault on a fetch (`req_acc` = 2) loads `ifsr` and `ifar` on the cycle after `done`. A fault on a read (0) or write (1) loads `dfsr` and `dfar` instead. The other pair keeps its value.
- R12: At most one descriptor read is outstanding at any time. A `req_valid` that arrives while a walk is in progress is ignored.
- R13: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-level access |
| tbl_base | input | 32 | First-level table base (bits 31:14 used) |
| dom_ctl | input | 32 | Sixteen 2-bit domain access values |
| proc_off | input | 32 | Offset added to low addresses |
| ctl_mmu_en | input | 1 | Translation enable |
| ctl_sys | input | 1 | System protection bit |
| ctl_rom | input | 1 | ROM protection bit |
| mem_rd_valid | output | 1 | Descriptor read request (one cycle) |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |
| done | output | 1 | Walk finished |
| pa | output | 32 | Physical address |
| perm_rd | output | 1 | Read granted |
| perm_wr | output | 1 | Write granted |
| fault | output | 1 | Walk ended in a fault |
| fault_status | output | 8 | {domain, code} of the fault |
| fault_addr | output | 32 | Working address of the walk |
| ifsr | output | 8 | Instruction-side fault status |
| ifar | output | 32 | Instruction-side fault address |
| dfsr | output | 8 | Data-side fault status |
| dfar | output | 32 | Data-side fault address |

## Verification
The assertions assume that the control inputs (`tbl_base`, `dom_ctl`, `proc_off` and the three control bits) stay stable from the accepted request until `done`. They also assume that memory answers each descriptor read with exactly one response, no earlier than the cycle after the request. The bench changes the control inputs only while the walker is idle. Its memory model returns data one cycle after each request and never sends a response on its own.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW    = 32;
    localparam int DOM_W = 4;
    localparam int CODE_W = 4;
    localparam int FSR_W = DOM_W + CODE_W;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [CODE_W-1:0] FC_XLAT_SECT = 4'd5;
    localparam logic [CODE_W-1:0] FC_XLAT_PAGE = 4'd7;
    localparam logic [CODE_W-1:0] FC_DOM_SECT  = 4'd9;
    localparam logic [CODE_W-1:0] FC_DOM_PAGE  = 4'd11;
    localparam logic [CODE_W-1:0] FC_PERM_SECT = 4'd13;
    localparam logic [CODE_W-1:0] FC_PERM_PAGE = 4'd15;

    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_CHECK, S_DONE
    } walk_state_e;

    typedef struct packed {
        walk_state_e       state;
        logic [AW-1:0]     va;
        logic [1:0]        acc;
        logic              user;
        logic              is_page;
        logic [DOM_W-1:0]  dom;
        logic [1:0]        dom_acc;
        logic [1:0]        ap;
        logic [AW-1:0]     pa;
        logic [AW-11:0]    tbl;
        logic              fault;
        logic [FSR_W-1:0]  fsr;
        logic              rd;
        logic              wr;
    } walk_st_t;

    typedef struct packed {
        logic [FSR_W-1:0] ifsr;
        logic [AW-1:0]    ifar;
        logic [FSR_W-1:0] dfsr;
        logic [AW-1:0]    dfar;
    } fbank_t;
endpackage

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [AW-1:0] desc,
    input  logic [15:0]   va_lo,
    output logic          xlat_fault,
    output logic [AW-1:0] pa,
    output logic [1:0]    ap
);
    logic [4:0] sub_idx;
    logic [1:0] unused_cb;

    assign unused_cb = desc[3:2];
    assign sub_idx   = 5'd4 + {2'b00, va_lo[15:14], 1'b0};

    always_comb begin
        xlat_fault = 1'b0;
        pa         = '0;
        ap         = '0;
        case (desc[1:0])
            2'd1: begin
                pa = {desc[AW-1:16], va_lo[15:0]};
                ap = desc[sub_idx +: 2];
            end
            2'd2: begin
                pa = {desc[AW-1:12], va_lo[11:0]};
                ap = desc[sub_idx +: 2];
            end
            2'd3: begin
                pa = {desc[AW-1:10], va_lo[9:0]};
                ap = desc[5:4];
            end
            default: xlat_fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic [1:0] ap,
    input  logic [1:0] dom_acc,
    input  logic       user,
    input  logic       is_write,
    input  logic       sys_bit,
    input  logic       rom_bit,
    output logic       grant_rd,
    output logic       grant_wr
);
    always_comb begin
        grant_rd = 1'b0;
        grant_wr = 1'b0;
        if (dom_acc == 2'd3) begin
            grant_rd = 1'b1;
            grant_wr = 1'b1;
        end else begin
            case (ap)
                2'd0: if (!is_write) begin
                    case ({rom_bit, sys_bit})
                        2'b01:   grant_rd = !user;
                        2'b10:   grant_rd = 1'b1;
                        default: grant_rd = 1'b0;
                    endcase
                end
                2'd1: begin
                    grant_rd = !user;
                    grant_wr = !user;
                end
                2'd2: begin
                    grant_rd = !(user && is_write);
                    grant_wr = !user;
                end
                default: begin
                    grant_rd = 1'b1;
                    grant_wr = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_fault_bank.sv
module ptw_fault_bank
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             is_fetch,
    input  logic [FSR_W-1:0] fsr_in,
    input  logic [AW-1:0]    far_in,
    output logic [FSR_W-1:0] ifsr,
    output logic [AW-1:0]    ifar,
    output logic [FSR_W-1:0] dfsr,
    output logic [AW-1:0]    dfar
);
    fbank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (upd) begin
            if (is_fetch) begin
                bank_d.ifsr = fsr_in;
                bank_d.ifar = far_in;
            end else begin
                bank_d.dfsr = fsr_in;
                bank_d.dfar = far_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign ifsr = bank_q.ifsr;
    assign ifar = bank_q.ifar;
    assign dfsr = bank_q.dfsr;
    assign dfar = bank_q.dfar;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter logic [AW-1:0] RELOC_LIMIT = 32'h0200_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_va,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    input  logic [AW-1:0]    tbl_base,
    input  logic [AW-1:0]    dom_ctl,
    input  logic [AW-1:0]    proc_off,
    input  logic             ctl_mmu_en,
    input  logic             ctl_sys,
    input  logic             ctl_rom,
    output logic             mem_rd_valid,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [AW-1:0]    mem_rsp_data,
    output logic             done,
    output logic [AW-1:0]    pa,
    output logic             perm_rd,
    output logic             perm_wr,
    output logic             fault,
    output logic [FSR_W-1:0] fault_status,
    output logic [AW-1:0]    fault_addr,
    output logic [FSR_W-1:0] ifsr,
    output logic [AW-1:0]    ifar,
    output logic [FSR_W-1:0] dfsr,
    output logic [AW-1:0]    dfar
);
    walk_st_t st_d, st_q;

    logic [DOM_W-1:0] l1_dom;
    logic [1:0]       l1_acc;
    logic [AW-1:0]    va_rel;
    logic             l2_fault;
    logic [AW-1:0]    l2_pa;
    logic [1:0]       l2_ap;
    logic             g_rd, g_wr;
    logic             cur_fetch;
    logic [13:0]      unused_base;

    assign unused_base = tbl_base[13:0];
    assign l1_dom      = mem_rsp_data[8:5];
    assign l1_acc      = dom_ctl[{l1_dom, 1'b0} +: 2];
    assign va_rel      = (req_va < RELOC_LIMIT) ? req_va + proc_off : req_va;
    assign cur_fetch   = (st_q.acc == ACC_FETCH);

    ptw_l2_decode i_l2 (
        .desc(mem_rsp_data), .va_lo(st_q.va[15:0]),
        .xlat_fault(l2_fault), .pa(l2_pa), .ap(l2_ap)
    );

    ptw_perm i_perm (
        .ap(st_q.ap), .dom_acc(st_q.dom_acc), .user(st_q.user),
        .is_write(st_q.acc == ACC_WRITE), .sys_bit(ctl_sys), .rom_bit(ctl_rom),
        .grant_rd(g_rd), .grant_wr(g_wr)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            S_IDLE: if (req_valid) begin
                st_d.va    = va_rel;
                st_d.pa    = va_rel;
                st_d.acc   = req_acc;
                st_d.user  = req_user;
                st_d.fault = 1'b0;
                st_d.fsr   = '0;
                st_d.dom   = '0;
                st_d.rd    = 1'b0;
                st_d.wr    = 1'b0;
                if (!ctl_mmu_en) begin
                    st_d.rd    = 1'b1;
                    st_d.wr    = 1'b1;
                    st_d.state = S_DONE;
                end else begin
                    st_d.state = S_L1_REQ;
                end
            end
            S_L1_REQ: st_d.state = S_L1_WAIT;
            S_L1_WAIT: if (mem_rsp_valid) begin
                st_d.dom     = l1_dom;
                st_d.dom_acc = l1_acc;
                st_d.is_page = mem_rsp_data[0];
                case (mem_rsp_data[1:0])
                    2'd0: begin
                        st_d.fault = 1'b1;
                        st_d.fsr   = {l1_dom, FC_XLAT_SECT};
                        st_d.state = S_DONE;
                    end
                    2'd2: begin
                        if (!l1_acc[0]) begin
                            st_d.fault = 1'b1;
                            st_d.fsr   = {l1_dom, FC_DOM_SECT};
                            st_d.state = S_DONE;
                        end else begin
                            st_d.pa    = {mem_rsp_data[AW-1:20], st_q.va[19:0]};
                            st_d.ap    = mem_rsp_data[11:10];
                            st_d.state = S_CHECK;
                        end
                    end
                    default: begin
                        if (!l1_acc[0]) begin
                            st_d.fault = 1'b1;
                            st_d.fsr   = {l1_dom, FC_DOM_PAGE};
                            st_d.state = S_DONE;
                        end else begin
                            st_d.tbl   = mem_rsp_data[AW-1:10];
                            st_d.state = S_L2_REQ;
                        end
                    end
                endcase
            end
            S_L2_REQ: st_d.state = S_L2_WAIT;
            S_L2_WAIT: if (mem_rsp_valid) begin
                if (l2_fault) begin
                    st_d.fault = 1'b1;
                    st_d.fsr   = {st_q.dom, FC_XLAT_PAGE};
                    st_d.state = S_DONE;
                end else begin
                    st_d.pa    = l2_pa;
                    st_d.ap    = l2_ap;
                    st_d.state = S_CHECK;
                end
            end
            S_CHECK: begin
                st_d.rd    = g_rd;
                st_d.wr    = g_wr;
                st_d.state = S_DONE;
                if (!g_rd && !g_wr) begin
                    st_d.fault = 1'b1;
                    st_d.fsr   = {st_q.dom, st_q.is_page ? FC_PERM_PAGE : FC_PERM_SECT};
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: S_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign mem_rd_valid = (st_q.state == S_L1_REQ) || (st_q.state == S_L2_REQ);
    assign mem_rd_addr  = (st_q.state == S_L2_REQ)
                        ? {st_q.tbl, st_q.va[19:12], 2'b00}
                        : {tbl_base[AW-1:14], st_q.va[31:20], 2'b00};
    assign done         = (st_q.state == S_DONE);
    assign pa           = st_q.pa;
    assign perm_rd      = st_q.rd;
    assign perm_wr      = st_q.wr;
    assign fault        = st_q.fault;
    assign fault_status = st_q.fsr;
    assign fault_addr   = st_q.va;

    ptw_fault_bank i_bank (
        .clk(clk), .rst_n(rst_n), .upd(done && st_q.fault), .is_fetch(cur_fetch),
        .fsr_in(st_q.fsr), .far_in(st_q.va),
        .ifsr(ifsr), .ifar(ifar), .dfsr(dfsr), .dfar(dfar)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rd_valid,
    input logic       mem_rsp_valid,
    input logic       done,
    input logic       fault,
    input logic       perm_rd,
    input logic       perm_wr,
    input logic       ctl_mmu_en,
    input logic       cur_fetch,
    input logic [7:0] ifsr,
    input logic [31:0] ifar,
    input logic [7:0] dfsr,
    input logic [31:0] dfar
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pend_q <= 1'b0;
        else if (mem_rd_valid)  pend_q <= 1'b1;
        else if (mem_rsp_valid) pend_q <= 1'b0;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !pend_q);                                   // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R13
    AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!perm_rd && !perm_wr));                 // R9
    AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> ctl_mmu_en);                                // R3
    AST_ISIDE_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ifsr) || !$stable(ifar)) |-> $past(done && fault && cur_fetch)); // R11
    AST_DSIDE_NOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dfsr) || !$stable(dfar)) |-> $past(done && fault && !cur_fetch)); // R11
endmodule

bind pt_walker ptw_checker i_ptw_checker (
    .clk(clk), .rst_n(rst_n), .mem_rd_valid(mem_rd_valid), .mem_rsp_valid(mem_rsp_valid),
    .done(done), .fault(fault), .perm_rd(perm_rd), .perm_wr(perm_wr),
    .ctl_mmu_en(ctl_mmu_en), .cur_fetch(cur_fetch),
    .ifsr(ifsr), .ifar(ifar), .dfsr(dfsr), .dfar(dfar)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam logic [31:0] TBASE = 32'h0004_0000;
    localparam logic [31:0] DOMS  = 32'h0000_008D; // d0 client, d1 manager, d2 none, d3 reserved

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] va;
        logic [1:0]  acc;
        logic        user;
        logic [2:0]  ctl;   // {rom, sys, en}
        logic [31:0] off;
        logic [31:0] l1;
        logic [31:0] l2;
        logic [1:0]  nrd;
        logic        flt;
        logic [7:0]  fsr;
        logic [31:0] pa;
        logic        rd;
        logic        wr;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        // R4 section, client, field 3
        '{4'd4,  32'h1234_5678, 2'd0, 1'b0, 3'b001, 32'h0, 32'hABC0_0C02, 32'h0, 2'd1, 1'b0, 8'h00, 32'hABC4_5678, 1'b1, 1'b1},
        // R8 manager ignores field 0 on a user write
        '{4'd8,  32'h3000_0ABC, 2'd1, 1'b1, 3'b001, 32'h0, 32'h5550_0022, 32'h0, 2'd1, 1'b0, 8'h00, 32'h5550_0ABC, 1'b1, 1'b1},
        // R5 section domain fault
        '{4'd5,  32'h4000_0000, 2'd0, 1'b0, 3'b001, 32'h0, 32'h1110_0C42, 32'h0, 2'd1, 1'b1, 8'h29, 32'h0, 1'b0, 1'b0},
        // R7 first-level translation fault on fetch
        '{4'd7,  32'h5000_1000, 2'd2, 1'b0, 3'b001, 32'h0, 32'h0000_0060, 32'h0, 2'd1, 1'b1, 8'h35, 32'h0, 1'b0, 1'b0},
        // R9 field 1 user read
        '{4'd9,  32'h6000_0000, 2'd0, 1'b1, 3'b001, 32'h0, 32'h2220_0402, 32'h0, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
        // R9 field 2 user read
        '{4'd9,  32'h7000_0004, 2'd0, 1'b1, 3'b001, 32'h0, 32'h3330_0802, 32'h0, 2'd1, 1'b0, 8'h00, 32'h3330_0004, 1'b1, 1'b0},
        // R9 field 2 user write
        '{4'd9,  32'h7000_0008, 2'd1, 1'b1, 3'b001, 32'h0, 32'h3330_0802, 32'h0, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
        // R10 field 0, sys, privileged read
        '{4'd10, 32'h7100_0010, 2'd0, 1'b0, 3'b011, 32'h0, 32'h4440_0002, 32'h0, 2'd1, 1'b0, 8'h00, 32'h4440_0010, 1'b1, 1'b0},
        // R10 field 0, sys, user read
        '{4'd10, 32'h7100_0010, 2'd0, 1'b1, 3'b011, 32'h0, 32'h4440_0002, 32'h0, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
        // R10 field 0, rom, user read
        '{4'd10, 32'h7100_0020, 2'd0, 1'b1, 3'b101, 32'h0, 32'h4440_0002, 32'h0, 2'd1, 1'b0, 8'h00, 32'h4440_0020, 1'b1, 1'b0},
        // R10 field 0, rom, privileged write
        '{4'd10, 32'h7100_0020, 2'd1, 1'b0, 3'b101, 32'h0, 32'h4440_0002, 32'h0, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
        // R11 field 0, both bits, fetch faults to instruction side
        '{4'd11, 32'h7100_0030, 2'd2, 1'b0, 3'b111, 32'h0, 32'h4440_0002, 32'h0, 2'd1, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0},
        // R6 4 KB page, subpage 3 is field 1, user read
        '{4'd6,  32'h1234_C678, 2'd0, 1'b1, 3'b001, 32'h0, 32'h0008_0401, 32'h9ABC_D7F2, 2'd2, 1'b1, 8'h0F, 32'h0, 1'b0, 1'b0},
        // R6 4 KB page privileged
        '{4'd6,  32'h1234_C678, 2'd0, 1'b0, 3'b001, 32'h0, 32'h0008_0401, 32'h9ABC_D7F2, 2'd2, 1'b0, 8'h00, 32'h9ABC_D678, 1'b1, 1'b1},
        // R6 64 KB page, subpage 1 is field 2
        '{4'd6,  32'h2000_5ABC, 2'd0, 1'b1, 3'b001, 32'h0, 32'h0008_0401, 32'h7777_0081, 2'd2, 1'b0, 8'h00, 32'h7777_5ABC, 1'b1, 1'b0},
        // R6 1 KB page under a type 3 table
        '{4'd6,  32'h2100_0123, 2'd1, 1'b1, 3'b001, 32'h0, 32'h0008_0403, 32'hCAFE_0C33, 2'd2, 1'b0, 8'h00, 32'hCAFE_0D23, 1'b1, 1'b1},
        // R7 second-level translation fault on fetch, domain 1
        '{4'd7,  32'h2200_0000, 2'd2, 1'b0, 3'b001, 32'h0, 32'h0008_0421, 32'h0, 2'd2, 1'b1, 8'h17, 32'h0, 1'b0, 1'b0},
        // R5 table domain fault, no second read
        '{4'd5,  32'h2300_0000, 2'd0, 1'b0, 3'b001, 32'h0, 32'h0008_0441, 32'h0, 2'd1, 1'b1, 8'h2B, 32'h0, 1'b0, 1'b0},
        // R3 translation off
        '{4'd3,  32'h3333_3333, 2'd1, 1'b1, 3'b000, 32'h0, 32'h0, 32'h0, 2'd0, 1'b0, 8'h00, 32'h3333_3333, 1'b1, 1'b1},
        // R2 low address relocated, translation off
        '{4'd2,  32'h0010_0000, 2'd0, 1'b0, 3'b000, 32'h0A00_0000, 32'h0, 32'h0, 2'd0, 1'b0, 8'h00, 32'h0A10_0000, 1'b1, 1'b1},
        // R2 relocated address walked
        '{4'd2,  32'h01F0_0004, 2'd0, 1'b0, 3'b001, 32'h0200_0000, 32'hABC0_0C02, 32'h0, 2'd1, 1'b0, 8'h00, 32'hABC0_0004, 1'b1, 1'b1},
        // R2 limit itself is not relocated
        '{4'd2,  32'h0200_0000, 2'd0, 1'b0, 3'b000, 32'h0A00_0000, 32'h0, 32'h0, 2'd0, 1'b0, 8'h00, 32'h0200_0000, 1'b1, 1'b1},
        // R8 manager on a page with field 0, user write
        '{4'd8,  32'h2400_0000, 2'd1, 1'b1, 3'b001, 32'h0, 32'h0008_0421, 32'h1234_5002, 2'd2, 1'b0, 8'h00, 32'h1234_5000, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [31:0] proc_off = '0;
    logic        ctl_mmu_en = 1'b0, ctl_sys = 1'b0, ctl_rom = 1'b0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, perm_rd, perm_wr, fault;
    logic [31:0] pa, fault_addr, ifar, dfar;
    logic [7:0]  fault_status, ifsr, dfsr;

    logic [31:0] cur_l1 = '0, cur_l2 = '0, got_a1 = '0, got_a2 = '0;
    int rd_cnt = 0;
    int base = 0;
    int n_chk = 0, n_bad = 0, cycles = 0;
    logic [7:0]  e_ifsr = '0, e_dfsr = '0;
    logic [31:0] e_ifar = '0, e_dfar = '0;

    always #2 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_acc(req_acc), .req_user(req_user), .tbl_base(TBASE), .dom_ctl(DOMS),
        .proc_off(proc_off), .ctl_mmu_en(ctl_mmu_en), .ctl_sys(ctl_sys), .ctl_rom(ctl_rom),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .pa(pa), .perm_rd(perm_rd), .perm_wr(perm_wr), .fault(fault),
        .fault_status(fault_status), .fault_addr(fault_addr),
        .ifsr(ifsr), .ifar(ifar), .dfsr(dfsr), .dfar(dfar)
    );

    // memory model: first read of a walk returns cur_l1, later ones cur_l2
    always @(posedge clk) begin
        mem_rsp_valid <= mem_rd_valid;
        if (mem_rd_valid) begin
            mem_rsp_data <= (rd_cnt == base) ? cur_l1 : cur_l2;
            if (rd_cnt == base) got_a1 <= mem_rd_addr;
            else                got_a2 <= mem_rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        chk(ifsr == e_ifsr, {tag, " R11 ifsr"}, {24'h0, ifsr}, {24'h0, e_ifsr});
        chk(ifar == e_ifar, {tag, " R11 ifar"}, ifar, e_ifar);
        chk(dfsr == e_dfsr, {tag, " R11 dfsr"}, {24'h0, dfsr}, {24'h0, e_dfsr});
        chk(dfar == e_dfar, {tag, " R11 dfar"}, dfar, e_dfar);
    endtask

    task automatic wait_done(input string tag);
        int w = 0;
        while (!done && w < 60) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, {tag, " R13 done seen"}, {31'h0, done}, 32'h1);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] wa;
        string tag;
        tag = $sformatf("vec%0d R%0d", idx, v.rq);
        wa  = (v.va < 32'h0200_0000) ? v.va + v.off : v.va;
        @(negedge clk);
        req_va = v.va; req_acc = v.acc; req_user = v.user; proc_off = v.off;
        {ctl_rom, ctl_sys, ctl_mmu_en} = v.ctl;
        cur_l1 = v.l1; cur_l2 = v.l2; base = rd_cnt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(tag);
        chk(fault == v.flt, {tag, " fault flag"}, {31'h0, fault}, {31'h0, v.flt});
        chk(rd_cnt - base == int'(v.nrd), {tag, " read count"}, rd_cnt - base, {30'h0, v.nrd});
        if (v.nrd >= 2'd1)
            chk(got_a1 == {TBASE[31:14], wa[31:20], 2'b00}, {tag, " R4 first address"},
                got_a1, {TBASE[31:14], wa[31:20], 2'b00});
        if (v.nrd == 2'd2)
            chk(got_a2 == {v.l1[31:10], wa[19:12], 2'b00}, {tag, " R6 second address"},
                got_a2, {v.l1[31:10], wa[19:12], 2'b00});
        if (v.flt) begin
            chk(fault_status == v.fsr, {tag, " status"}, {24'h0, fault_status}, {24'h0, v.fsr});
            chk(fault_addr == wa, {tag, " R2 fault address"}, fault_addr, wa);
            if (v.acc == 2'd2) begin e_ifsr = v.fsr; e_ifar = wa; end
            else               begin e_dfsr = v.fsr; e_dfar = wa; end
        end else begin
            chk(pa == v.pa, {tag, " pa"}, pa, v.pa);
        end
        chk({perm_rd, perm_wr} == {v.rd, v.wr}, {tag, " rights"},
            {30'h0, perm_rd, perm_wr}, {30'h0, v.rd, v.wr});
        @(negedge clk);
        chk(done == 1'b0, {tag, " R13 done one cycle"}, {31'h0, done}, 32'h0);
        check_bank(tag);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done in reset", {31'h0, done}, 32'h0);
        chk(mem_rd_valid == 1'b0, "R1 read request in reset", {31'h0, mem_rd_valid}, 32'h0);
        chk(fault == 1'b0, "R1 fault in reset", {31'h0, fault}, 32'h0);
        check_bank("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_rd_valid == 1'b0, "R1 idle after reset", {31'h0, mem_rd_valid}, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R12 a second request during a walk is ignored
        @(negedge clk);
        req_va = 32'h1234_5678; req_acc = 2'd0; req_user = 1'b0; proc_off = '0;
        {ctl_rom, ctl_sys, ctl_mmu_en} = 3'b001;
        cur_l1 = 32'hABC0_0C02; cur_l2 = '0; base = rd_cnt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_va = 32'h5555_0000; req_acc = 2'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R12 busy");
        chk(pa == 32'hABC4_5678, "R12 first request result kept", pa, 32'hABC4_5678);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R12 no second walk", {31'h0, done}, 32'h0);
        end
        chk(rd_cnt - base == 1, "R12 single read for ignored request", rd_cnt - base, 32'h1);
        check_bank("R12 busy");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule